// File: doc/BRIEF.md
# Per-Stream Ingress Gate Policer

This block sits on the receive side of a switch port group and decides, for every parsed frame, whether the frame belongs to a configured stream and what happens to it. Each frame presents its destination MAC address, VLAN ID, priority code point, ingress port, length and the current time. The time is counted in slots of a fixed grid, 200 ns in the intended system. The block looks these up in a table of stream rules. The lowest-numbered rule that matches decides the outcome. A rule either matches on the destination MAC alone, or on the MAC together with the VLAN ID and priority code point. A rule applies only on the ingress ports named in its own port mask, so one rule, and one schedule, can serve several ports at once.

A matched frame is dropped when any of these holds: the rule's explicit drop action is set; the rule is gated and the frame arrives while its cyclic open/close schedule is closed; the frame is longer than the rule's MTU; or the rule leaves the frame with no destination ports and no trap to the CPU. Otherwise the frame leaves with the rule's destination port mask and trap flag. A frame that matches no rule is flagged as a miss and is not changed in any way. Each rule has a saturating drop counter, and software can read it and clear it.

The rule table is written one 32-bit word at a time through a simple write port. Frame storage and buffer management belong to the surrounding logic. The decision is presented one clock after the frame's fields.

Top module: `stream_gate_policer`

## Requirements
- R1: After reset no rule is valid, every drop counter reads zero, res_valid is low, and any frame is reported as a miss.
- R2: A table write stores cfg_data into word cfg_word of rule cfg_rule. The word layout is as follows. Word 0 holds MAC[31:0]. Word 1 holds MAC[47:32] in bits 15:0, valid in bit 16, VLAN-aware in bit 17, gated in bit 18, trap in bit 19 and drop action in bit 20. Word 2 holds the VID in bits 11:0, the PCP in bits 14:12, the ingress port mask in bits 23:16 and the destination port mask in bits 31:24. Word 3 holds the MTU in bits 13:0. Word 4 holds the schedule base slot in bits 19:0. Word 5 holds the open length in bits 11:0 and the close length in bits 27:16. Any write to word 6 clears that rule's drop counter.
- R3: A valid rule that is not VLAN-aware matches a frame when the MAC is equal and the frame's ingress port bit is set in the rule's ingress mask. The VID and PCP have no effect on this match.
- R4: A VLAN-aware rule matches only when the MAC, the VID and the PCP are all equal, and the ingress port is enabled.
- R5: When several rules match, the rule with the lowest index decides, and its index appears on res_rule.
- R6: A frame that matches no rule gives res_miss=1, res_drop=0, res_ports=0 and res_trap=0.
- R7: A matched frame that is not dropped gives res_ports equal to the rule's destination mask and res_trap equal to the rule's trap bit. Redirect and trap can be set together.
- R8: A rule with its drop action set drops every frame it matches.
- R9: A gated rule is open at slot t only when t >= base and (t - base) mod (open + close) < open. A frame that arrives while the gate is closed, or before the base slot, is dropped. An ungated rule is always open.
- R10: A frame longer than the rule's MTU is dropped. A frame exactly as long as the MTU is accepted.
- R11: A matched frame is dropped when the rule has an empty destination mask and no trap. This also covers a gated rule that carries no redirect or trap action.
- R12: Every dropped frame adds one to the drop counter of its rule. The counter holds at all-ones and does not wrap. cnt_value shows the counter that cnt_sel selects.
- R13: A clear write sets the counter to zero. If a drop happens in the same cycle as the clear, the clear wins.
- R14: res_valid is high in exactly the cycle after the cycle in which frm_valid is high, and the decision fields are valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Table word write strobe |
| cfg_rule | input | $clog2(NUM_RULES) | Rule index to write |
| cfg_word | input | 3 | Word index within the rule |
| cfg_data | input | 32 | Write data |
| frm_valid | input | 1 | Frame fields present |
| frm_mac | input | 48 | Destination MAC |
| frm_vid | input | 12 | VLAN ID |
| frm_pcp | input | 3 | Priority code point |
| frm_port | input | $clog2(NUM_PORTS) | Ingress port |
| frm_len | input | 14 | Frame length in bytes |
| frm_slot | input | 20 | Current time in grid slots |
| res_valid | output | 1 | Decision present |
| res_miss | output | 1 | No rule matched |
| res_drop | output | 1 | Frame dropped |
| res_ports | output | NUM_PORTS | Destination port mask |
| res_trap | output | 1 | Copy to CPU |
| res_rule | output | $clog2(NUM_RULES) | Index of the deciding rule |
| cnt_sel | input | $clog2(NUM_RULES) | Counter to read |
| cnt_value | output | CNT_W | Selected drop counter |

## Verification
The bench keeps the full table of 16 rules and 5 ports, but builds the counters with CNT_W=4. With that width, saturation is reached after fifteen drops, so the test can drive a counter past all-ones and see that it holds. The gate is exercised on the slot just before its base and on both edges of the open and closed phases. It is also exercised on a phase reached after a hundred cycles, from several ingress ports that share the rule. Priority is shown by two rules on one MAC whose ingress masks partly overlap.

// File: rtl/sgp_pkg.sv
// Shared widths and the stored rule record for the stream gate policer.
package sgp_pkg;
    localparam int MAC_W  = 48;
    localparam int VID_W  = 12;
    localparam int PCP_W  = 3;
    localparam int PMAX   = 8;   // widest port mask a rule can hold
    localparam int LEN_W  = 14;
    localparam int TIME_W = 20;
    localparam int IVL_W  = 12;

    typedef struct packed {
        logic              valid;
        logic              aware;
        logic              gated;
        logic              trap;
        logic              act_drop;
        logic [MAC_W-1:0]  mac;
        logic [VID_W-1:0]  vid;
        logic [PCP_W-1:0]  pcp;
        logic [PMAX-1:0]   in_mask;
        logic [PMAX-1:0]   dst_mask;
        logic [LEN_W-1:0]  mtu;
        logic [TIME_W-1:0] base;
        logic [IVL_W-1:0]  open_len;
        logic [IVL_W-1:0]  close_len;
    } rule_t;
endpackage

// File: rtl/sgp_rule_table.sv
// Rule storage written one 32-bit word at a time; also decodes counter clears.
// Assumes cfg_rule < NUM_RULES; out-of-range writes are ignored.
module sgp_rule_table
    import sgp_pkg::*;
#(
    parameter int NUM_RULES = 16,
    localparam int RIDX_W = $clog2(NUM_RULES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [RIDX_W-1:0] cfg_rule,
    input  logic [2:0]        cfg_word,
    input  logic [31:0]       cfg_data,
    output rule_t             rules [NUM_RULES],
    output logic [NUM_RULES-1:0] clr_vec
);
    for (genvar i = 0; i < NUM_RULES; i++) begin : g_rule
        logic sel;
        assign sel        = cfg_we && (cfg_rule == RIDX_W'(i));
        assign clr_vec[i] = sel && (cfg_word == 3'd6);

        // Update the addressed word of this rule; reset leaves the rule invalid.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rules[i] <= '0;
            end else if (sel) begin
                case (cfg_word)
                    3'd0: rules[i].mac[31:0] <= cfg_data;
                    3'd1: begin
                        rules[i].mac[47:32] <= cfg_data[15:0];
                        rules[i].valid      <= cfg_data[16];
                        rules[i].aware      <= cfg_data[17];
                        rules[i].gated      <= cfg_data[18];
                        rules[i].trap       <= cfg_data[19];
                        rules[i].act_drop   <= cfg_data[20];
                    end
                    3'd2: begin
                        rules[i].vid      <= cfg_data[11:0];
                        rules[i].pcp      <= cfg_data[14:12];
                        rules[i].in_mask  <= cfg_data[23:16];
                        rules[i].dst_mask <= cfg_data[31:24];
                    end
                    3'd3: rules[i].mtu       <= cfg_data[LEN_W-1:0];
                    3'd4: rules[i].base      <= cfg_data[TIME_W-1:0];
                    3'd5: begin
                        rules[i].open_len  <= cfg_data[IVL_W-1:0];
                        rules[i].close_len <= cfg_data[16+IVL_W-1:16];
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/sgp_matcher.sv
// Compares one frame against every rule in parallel and picks the lowest
// matching index. Assumes frm_port < PMAX.
module sgp_matcher
    import sgp_pkg::*;
#(
    parameter int NUM_RULES = 16,
    parameter int PORT_IW   = 3,
    localparam int RIDX_W = $clog2(NUM_RULES)
) (
    input  rule_t              rules [NUM_RULES],
    input  logic [MAC_W-1:0]   frm_mac,
    input  logic [VID_W-1:0]   frm_vid,
    input  logic [PCP_W-1:0]   frm_pcp,
    input  logic [PORT_IW-1:0] frm_port,
    output logic               hit,
    output logic [RIDX_W-1:0]  hit_idx
);
    logic [NUM_RULES-1:0] match_vec;

    for (genvar i = 0; i < NUM_RULES; i++) begin : g_cmp
        logic tag_ok;
        assign tag_ok = !rules[i].aware ||
                        (rules[i].vid == frm_vid && rules[i].pcp == frm_pcp);
        assign match_vec[i] = rules[i].valid && (rules[i].mac == frm_mac) && tag_ok &&
                              rules[i].in_mask[frm_port];
    end

    // Priority encode: scan downward so the lowest matching index is kept.
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = NUM_RULES - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                hit     = 1'b1;
                hit_idx = RIDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/sgp_gate_eval.sv
// Decides whether the selected rule's cyclic gate is open at the given slot.
// One shared instance serves the winning rule only. Assumes TIME_W > IVL_W.
module sgp_gate_eval
    import sgp_pkg::*;
(
    input  logic              gated,
    input  logic [TIME_W-1:0] now,
    input  logic [TIME_W-1:0] base,
    input  logic [IVL_W-1:0]  open_len,
    input  logic [IVL_W-1:0]  close_len,
    output logic              is_open
);
    logic [TIME_W-1:0] delta, cycle_len, phase;

    // Phase within the cycle; a zero-length cycle counts as always closed.
    always_comb begin
        delta     = now - base;
        cycle_len = TIME_W'(open_len) + TIME_W'(close_len);
        phase     = (cycle_len == '0) ? '0 : (delta % cycle_len);
        is_open   = !gated ||
                    ((open_len != '0) && (now >= base) && (phase < TIME_W'(open_len)));
    end
endmodule

// File: rtl/sgp_drop_counters.sv
// One saturating drop counter per rule, cleared by a table write.
module sgp_drop_counters #(
    parameter int NUM_RULES = 16,
    parameter int CNT_W     = 32,
    localparam int RIDX_W = $clog2(NUM_RULES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_RULES-1:0] inc_vec,
    input  logic [NUM_RULES-1:0] clr_vec,
    input  logic [RIDX_W-1:0]    cnt_sel,
    output logic [CNT_W-1:0]     cnt_value
);
    logic [CNT_W-1:0] cnt [NUM_RULES];

    for (genvar i = 0; i < NUM_RULES; i++) begin : g_cnt
        // Clear has priority; otherwise count drops and hold at all-ones.
        always_ff @(posedge clk) begin
            if (!rst_n || clr_vec[i])
                cnt[i] <= '0;
            else if (inc_vec[i] && cnt[i] != '1)
                cnt[i] <= cnt[i] + 1'b1;
        end

        AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
            !clr_vec[i] |=> cnt[i] >= $past(cnt[i])); // R12
        AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
            clr_vec[i] |=> cnt[i] == '0); // R13
    end

    assign cnt_value = cnt[cnt_sel];
endmodule

// File: rtl/stream_gate_policer.sv
// Per-stream ingress policer: matches each frame against the rule table, checks
// gate, MTU and action, and registers one decision per frame one cycle later.
// Assumes NUM_PORTS <= 8 and one frame per cycle at most.
module stream_gate_policer
    import sgp_pkg::*;
#(
    parameter int NUM_RULES = 16,
    parameter int NUM_PORTS = 5,
    parameter int CNT_W     = 32,
    localparam int RIDX_W  = $clog2(NUM_RULES),
    localparam int PORT_IW = $clog2(NUM_PORTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [RIDX_W-1:0]    cfg_rule,
    input  logic [2:0]           cfg_word,
    input  logic [31:0]          cfg_data,
    input  logic                 frm_valid,
    input  logic [MAC_W-1:0]     frm_mac,
    input  logic [VID_W-1:0]     frm_vid,
    input  logic [PCP_W-1:0]     frm_pcp,
    input  logic [PORT_IW-1:0]   frm_port,
    input  logic [LEN_W-1:0]     frm_len,
    input  logic [TIME_W-1:0]    frm_slot,
    output logic                 res_valid,
    output logic                 res_miss,
    output logic                 res_drop,
    output logic [NUM_PORTS-1:0] res_ports,
    output logic                 res_trap,
    output logic [RIDX_W-1:0]    res_rule,
    input  logic [RIDX_W-1:0]    cnt_sel,
    output logic [CNT_W-1:0]     cnt_value
);
    rule_t                rules [NUM_RULES];
    logic [NUM_RULES-1:0] clr_vec, inc_vec;
    logic                 hit, gate_open, drop_now;
    logic [RIDX_W-1:0]    hit_idx;
    rule_t                win;
    logic [NUM_PORTS-1:0] dst;

    sgp_rule_table #(.NUM_RULES(NUM_RULES)) u_table (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_rule(cfg_rule),
        .cfg_word(cfg_word), .cfg_data(cfg_data), .rules(rules), .clr_vec(clr_vec)
    );

    sgp_matcher #(.NUM_RULES(NUM_RULES), .PORT_IW(PORT_IW)) u_match (
        .rules(rules), .frm_mac(frm_mac), .frm_vid(frm_vid), .frm_pcp(frm_pcp),
        .frm_port(frm_port), .hit(hit), .hit_idx(hit_idx)
    );

    assign win = rules[hit_idx];
    assign dst = win.dst_mask[NUM_PORTS-1:0];

    sgp_gate_eval u_gate (
        .gated(win.gated), .now(frm_slot), .base(win.base),
        .open_len(win.open_len), .close_len(win.close_len), .is_open(gate_open)
    );

    // Combine every drop cause of the winning rule into one decision.
    always_comb begin
        drop_now = win.act_drop || !gate_open || (frm_len > win.mtu) ||
                   (dst == '0 && !win.trap);
        inc_vec  = '0;
        if (frm_valid && hit && drop_now)
            inc_vec[hit_idx] = 1'b1;
    end

    sgp_drop_counters #(.NUM_RULES(NUM_RULES), .CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .inc_vec(inc_vec), .clr_vec(clr_vec),
        .cnt_sel(cnt_sel), .cnt_value(cnt_value)
    );

    // Register the decision for the frame presented this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_miss  <= 1'b0;
            res_drop  <= 1'b0;
            res_ports <= '0;
            res_trap  <= 1'b0;
            res_rule  <= '0;
        end else begin
            res_valid <= frm_valid;
            res_miss  <= frm_valid && !hit;
            res_drop  <= frm_valid && hit && drop_now;
            res_ports <= (frm_valid && hit && !drop_now) ? dst : '0;
            res_trap  <= frm_valid && hit && !drop_now && win.trap;
            res_rule  <= hit ? hit_idx : '0;
        end
    end

    AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |=> res_valid); // R14
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_valid |=> !res_valid); // R14
    AST_MISS_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_miss |-> !res_drop && res_ports == '0 && !res_trap); // R6
    AST_DROP_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_drop |-> res_ports == '0 && !res_trap && !res_miss); // R8
endmodule

// File: tb/sim_stream_gate_policer.sv
module sim_stream_gate_policer;
    localparam int NR = 16;
    localparam int NP = 5;
    localparam int CW = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_rule = '0;
    logic [2:0]  cfg_word = '0;
    logic [31:0] cfg_data = '0;
    logic        frm_valid = 1'b0;
    logic [47:0] frm_mac = '0;
    logic [11:0] frm_vid = '0;
    logic [2:0]  frm_pcp = '0;
    logic [2:0]  frm_port = '0;
    logic [13:0] frm_len = '0;
    logic [19:0] frm_slot = '0;
    logic        res_valid, res_miss, res_drop, res_trap;
    logic [NP-1:0] res_ports;
    logic [3:0]  res_rule;
    logic [3:0]  cnt_sel = '0;
    logic [CW-1:0] cnt_value;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    stream_gate_policer #(.NUM_RULES(NR), .NUM_PORTS(NP), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_rule(cfg_rule),
        .cfg_word(cfg_word), .cfg_data(cfg_data), .frm_valid(frm_valid),
        .frm_mac(frm_mac), .frm_vid(frm_vid), .frm_pcp(frm_pcp), .frm_port(frm_port),
        .frm_len(frm_len), .frm_slot(frm_slot), .res_valid(res_valid),
        .res_miss(res_miss), .res_drop(res_drop), .res_ports(res_ports),
        .res_trap(res_trap), .res_rule(res_rule), .cnt_sel(cnt_sel),
        .cnt_value(cnt_value)
    );

    localparam logic [47:0] MA = 48'h0200_0000_00AA, MB = 48'h0200_0000_00BB,
                            MC = 48'h0200_0000_00CC, MD = 48'h0200_0000_00DD,
                            ME = 48'h0200_0000_00EE, MF = 48'h0200_0000_00FF;

    typedef struct packed {
        logic [47:0] mac; logic [11:0] vid; logic [2:0] pcp; logic [2:0] port;
        logic [13:0] len; logic [19:0] t;
        logic miss; logic drop; logic [4:0] ports; logic trap; logic [3:0] rule;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{MA, 12'd5,   3'd0, 3'd0, 14'd100, 20'd0,    1'b0, 1'b0, 5'b01100, 1'b0, 4'd0}, // R3 R5
        '{MA, 12'd999, 3'd7, 3'd1, 14'd100, 20'd0,    1'b0, 1'b0, 5'b01100, 1'b0, 4'd0}, // R3 tag ignored
        '{MA, 12'd5,   3'd0, 3'd3, 14'd100, 20'd0,    1'b0, 1'b0, 5'b00000, 1'b1, 4'd2}, // R3 mask, R5
        '{MB, 12'd100, 3'd3, 3'd2, 14'd100, 20'd0,    1'b0, 1'b0, 5'b10000, 1'b1, 4'd1}, // R4 R7
        '{MB, 12'd101, 3'd3, 3'd2, 14'd100, 20'd0,    1'b1, 1'b0, 5'b00000, 1'b0, 4'd0}, // R4 vid
        '{MB, 12'd100, 3'd2, 3'd2, 14'd100, 20'd0,    1'b1, 1'b0, 5'b00000, 1'b0, 4'd0}, // R4 pcp
        '{48'h123,12'd0,3'd0, 3'd0, 14'd100, 20'd0,    1'b1, 1'b0, 5'b00000, 1'b0, 4'd0}, // R6
        '{MC, 12'd0,   3'd0, 3'd1, 14'd100, 20'd99,   1'b0, 1'b1, 5'b00000, 1'b0, 4'd3}, // R9 pre-base
        '{MC, 12'd0,   3'd0, 3'd1, 14'd100, 20'd100,  1'b0, 1'b0, 5'b00010, 1'b0, 4'd3}, // R9
        '{MC, 12'd0,   3'd0, 3'd1, 14'd100, 20'd105,  1'b0, 1'b0, 5'b00010, 1'b0, 4'd3}, // R9
        '{MC, 12'd0,   3'd0, 3'd1, 14'd100, 20'd106,  1'b0, 1'b1, 5'b00000, 1'b0, 4'd3}, // R9
        '{MC, 12'd0,   3'd0, 3'd1, 14'd100, 20'd109,  1'b0, 1'b1, 5'b00000, 1'b0, 4'd3}, // R9
        '{MC, 12'd0,   3'd0, 3'd4, 14'd100, 20'd110,  1'b0, 1'b0, 5'b00010, 1'b0, 4'd3}, // R9 shared
        '{MC, 12'd0,   3'd0, 3'd2, 14'd100, 20'd1115, 1'b0, 1'b0, 5'b00010, 1'b0, 4'd3}, // R9
        '{MC, 12'd0,   3'd0, 3'd0, 14'd100, 20'd1117, 1'b0, 1'b1, 5'b00000, 1'b0, 4'd3}, // R9
        '{MD, 12'd0,   3'd0, 3'd0, 14'd100, 20'd0,    1'b0, 1'b1, 5'b00000, 1'b0, 4'd4}, // R8
        '{ME, 12'd0,   3'd0, 3'd0, 14'd100, 20'd0,    1'b0, 1'b1, 5'b00000, 1'b0, 4'd5}, // R11
        '{MF, 12'd0,   3'd0, 3'd0, 14'd64,  20'd0,    1'b0, 1'b0, 5'b00001, 1'b0, 4'd6}, // R10
        '{MF, 12'd0,   3'd0, 3'd0, 14'd65,  20'd0,    1'b0, 1'b1, 5'b00000, 1'b0, 4'd6}  // R10
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int r, input int w, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_rule = 4'(r); cfg_word = 3'(w); cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_rule(input int r, input logic [47:0] mac, input logic [4:0] flags,
                            input logic [31:0] w2, input int mtu, input int base,
                            input int op, input int cl);
        wr(r, 0, mac[31:0]);
        wr(r, 1, {11'd0, flags, mac[47:32]});
        wr(r, 2, w2);
        wr(r, 3, 32'(mtu));
        wr(r, 4, 32'(base));
        wr(r, 5, {4'd0, 12'(cl), 4'd0, 12'(op)});
    endtask

    // Present one frame; outputs are sampled 1 ns after the capturing edge.
    task automatic send(input logic [47:0] mac, input logic [11:0] vid, input logic [2:0] pcp,
                        input logic [2:0] port, input logic [13:0] len, input logic [19:0] t);
        @(negedge clk);
        frm_valid = 1'b1; frm_mac = mac; frm_vid = vid; frm_pcp = pcp;
        frm_port = port; frm_len = len; frm_slot = t;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        frm_valid = 1'b0;
    endtask

    task automatic read_cnt(input int r, output logic [CW-1:0] v);
        @(negedge clk);
        cnt_sel = 4'(r);
        #1;
        v = cnt_value;
    endtask

    function automatic void finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [CW-1:0] c;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1 res_valid", 32'(res_valid), 0);
        for (int r = 0; r < NR; r++) begin
            read_cnt(r, c);
            check("R1 counter", 32'(c), 0);
        end
        send(MA, 0, 0, 0, 100, 0);
        check("R1 miss before config", 32'(res_miss), 1);
        idle();

        // R2: rule programming; flags = {drop,trap,gated,aware,valid}
        set_rule(0, MA, 5'b00001, {8'b01100, 8'b00011, 16'd0}, 1500, 0, 0, 0);
        set_rule(1, MB, 5'b01011, {8'b10000, 8'b11111, 1'b0, 3'd3, 12'd100}, 1500, 0, 0, 0);
        set_rule(2, MA, 5'b01001, {8'b00000, 8'b11111, 16'd0}, 1500, 0, 0, 0);
        set_rule(3, MC, 5'b00101, {8'b00010, 8'b11111, 16'd0}, 1500, 100, 6, 4);
        set_rule(4, MD, 5'b10001, {8'b00001, 8'b11111, 16'd0}, 1500, 0, 0, 0);
        set_rule(5, ME, 5'b00101, {8'b00000, 8'b11111, 16'd0}, 1500, 0, 10, 0);
        set_rule(6, MF, 5'b00001, {8'b00001, 8'b11111, 16'd0}, 64, 0, 0, 0);

        // Vector table walk (R2..R11)
        for (int i = 0; i < NV; i++) begin
            send(VECS[i].mac, VECS[i].vid, VECS[i].pcp, VECS[i].port, VECS[i].len, VECS[i].t);
            check($sformatf("R14 valid v%0d", i), 32'(res_valid), 1);
            check($sformatf("R6 miss v%0d", i), 32'(res_miss), 32'(VECS[i].miss));
            check($sformatf("R9 drop v%0d", i), 32'(res_drop), 32'(VECS[i].drop));
            check($sformatf("R7 ports v%0d", i), 32'(res_ports), 32'(VECS[i].ports));
            check($sformatf("R7 trap v%0d", i), 32'(res_trap), 32'(VECS[i].trap));
            if (!VECS[i].miss)
                check($sformatf("R5 rule v%0d", i), 32'(res_rule), 32'(VECS[i].rule));
            idle();
        end
        @(posedge clk); #1;
        check("R14 no result without frame", 32'(res_valid), 0);

        // R12: per-rule drop counts after the walk
        read_cnt(3, c); check("R12 rule3 drops", 32'(c), 4);
        read_cnt(4, c); check("R12 rule4 drops", 32'(c), 1);
        read_cnt(5, c); check("R11 rule5 drops", 32'(c), 1);
        read_cnt(6, c); check("R10 rule6 drops", 32'(c), 1);
        read_cnt(0, c); check("R12 rule0 no drops", 32'(c), 0);

        // R12: saturation at all-ones
        for (int k = 0; k < 20; k++) send(MD, 0, 0, 1, 100, 0);
        idle();
        read_cnt(4, c); check("R12 saturate", 32'(c), 15);

        // R13: clear, then clear colliding with a drop
        wr(4, 6, 0);
        read_cnt(4, c); check("R13 clear", 32'(c), 0);
        send(MD, 0, 0, 0, 100, 0);
        idle();
        read_cnt(4, c); check("R13 count after clear", 32'(c), 1);
        @(negedge clk);
        frm_valid = 1'b1; frm_mac = MD; frm_port = 0; frm_len = 100; frm_slot = 0;
        cfg_we = 1'b1; cfg_rule = 4'd4; cfg_word = 3'd6;
        @(negedge clk);
        frm_valid = 1'b0; cfg_we = 1'b0;
        read_cnt(4, c); check("R13 clear beats drop", 32'(c), 0);

        // R3: disabling port 0 in rule 0's mask moves port-0 traffic to rule 2
        wr(0, 2, {8'b01100, 8'b00010, 16'd0});
        send(MA, 0, 0, 0, 100, 0);
        check("R3 ingress mask rule", 32'(res_rule), 2);
        idle();

        finish_run();
    end
endmodule